// File: doc/BRIEF.md
# Debug Register Access Command Engine

This block sits behind a serial debug port, after the shifter, and carries out the two commands that move a longword to or from one of the processor's address or data registers. The host and the block trade one 16-bit word per transfer slot, and the port's shifter marks each slot with a one-cycle strobe. On each slot the block takes in the word the host sends. Once the clock edge has passed, it presents the response word the host collects for that slot: a status bit plus 16 data bits.

A read command is answered over the next two slots, upper half first and then lower half. A write command takes its operand over the next two slots, upper half first. The block commits the full 32 bits in a single register-file write, then confirms in one more slot. The register file sits outside the block and is reached through an address, a read strobe with a combinational read path, and a write strobe. Access is allowed only while the core reports that it is halted. Otherwise the command ends with a bus-error response and the register file is left untouched. Words that are not valid register commands end with an illegal-command response.

Top module: `dbgreg_cmd_engine`

## Requirements
- R1: A command word is a legal register command only when bits 15:12 are 0x2 and bits 7:4 are 0x8. Bits 11:8 give the operation: 0x1 for read and 0x0 for write. Bit 3 selects address (1) or data (0) registers, and bits 2:0 give the register number. rf_addr_o carries {bit 3, bits 2:0}.
- R2: The response collected in a command slot is not-ready (status 1, data 0x0000). The responses in the write operand slots are also not-ready.
- R3: For a read while halted, the slot after the command returns status 0 with register bits 31:16. The slot after that returns status 0 with bits 15:0.
- R4: For a write while halted, the two slots after the command carry operand bits 31:16 and then bits 15:0. On the second operand slot, rf_we_o pulses for one cycle with all 32 bits on rf_wdata_o. The next slot returns status 0, data 0xFFFF.
- R5: For a read while not halted, the slot after the command returns bus error (status 1, data 0x0001) and rf_re_o stays low.
- R6: For a write while not halted, no register-file write occurs, and the fourth slot returns bus error (status 1, data 0x0001).
- R7: An illegal command word gets a not-ready response in its own slot and status 1, data 0xFFFF in the next slot. It causes no register-file access.
- R8: After the last slot of any response sequence, the very next slot is decoded as a new command.
- R9: During and right after reset, the response is status 0, data 0x0000, and both register-file strobes are low.
- R10: The response word changes only on the clock edge of a transfer slot.
- R11: rf_re_o and rf_we_o are never high together, are asserted only in a slot cycle, and are asserted only while halted_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| xfer_i | input | 1 | One-cycle transfer slot strobe |
| word_i | input | 16 | Word received from the host in this slot |
| halted_i | input | 1 | Core is halted |
| resp_status_o | output | 1 | Response status bit (1 = error or not ready) |
| resp_data_o | output | 16 | Response data word |
| rf_addr_o | output | 4 | Register select {addr/data, number} |
| rf_re_o | output | 1 | Register-file read strobe |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_wdata_o | output | 32 | Register-file write data |
| rf_rdata_i | input | 32 | Register-file read data, combinational from rf_addr_o |

## Verification
The assertions check, on every cycle, that the response word holds still between slots and that every command slot is answered with not-ready. They also check that the two register-file strobes never overlap, never fire outside a slot and never fire while the core runs, and that a read strobe is followed by the upper half of the data it fetched. The register values that come back, the sequences of slots, the bus-error and illegal-command endings, and the fact that the next slot is taken as a fresh command are shown only by the bench. It sweeps all sixteen registers in both halt states and every value of each opcode field, and compares against its own copy of the register file.

// File: rtl/dbgreg_cmd_pkg.sv
package dbgreg_cmd_pkg;
  localparam int unsigned CMD_W = 16;

  localparam logic [3:0] GRP_REG = 4'h2;
  localparam logic [3:0] OP_RD   = 4'h1;
  localparam logic [3:0] OP_WR   = 4'h0;
  localparam logic [3:0] SUB_REG = 4'h8;

  localparam logic [CMD_W-1:0] D_NOT_READY = 16'h0000;
  localparam logic [CMD_W-1:0] D_BUS_ERR   = 16'h0001;
  localparam logic [CMD_W-1:0] D_ILLEGAL   = 16'hFFFF;
  localparam logic [CMD_W-1:0] D_DONE      = 16'hFFFF;

  typedef enum logic [1:0] {CMD_ILL, CMD_RD, CMD_WR} cmd_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_HI, S_RD_LO, S_WR_HI, S_WR_LO, S_WR_DONE, S_ILL
  } seq_state_e;

  typedef struct packed {
    logic             status;
    logic [CMD_W-1:0] data;
  } resp_t;
endpackage

// File: rtl/dbgreg_cmd_decode.sv
module dbgreg_cmd_decode
  import dbgreg_cmd_pkg::*;
#(
  parameter int unsigned NUM_W = 3
) (
  input  logic [CMD_W-1:0] word_i,
  output cmd_kind_e        kind_o,
  output logic [NUM_W:0]   idx_o
);
  localparam int unsigned GRP_LSB = 12;
  localparam int unsigned OP_LSB  = 8;
  localparam int unsigned SUB_LSB = 4;
  localparam int unsigned AD_BIT  = 3;

  logic [3:0] grp, op, sub;
  logic       frame_ok;

  assign grp      = word_i[GRP_LSB +: 4];
  assign op       = word_i[OP_LSB  +: 4];
  assign sub      = word_i[SUB_LSB +: 4];
  assign frame_ok = (grp == GRP_REG) && (sub == SUB_REG);
  assign idx_o    = {word_i[AD_BIT], word_i[NUM_W-1:0]};

  always_comb begin
    kind_o = CMD_ILL;
    if (frame_ok) begin
      if (op == OP_RD)      kind_o = CMD_RD;
      else if (op == OP_WR) kind_o = CMD_WR;
    end
  end
endmodule

// File: rtl/dbgreg_cmd_seq.sv
module dbgreg_cmd_seq
  import dbgreg_cmd_pkg::*;
#(
  parameter int unsigned NUM_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               xfer_i,
  input  logic [CMD_W-1:0]   word_i,
  input  logic               halted_i,
  input  cmd_kind_e          kind_i,
  input  logic [NUM_W:0]     idx_i,
  output resp_t              resp_o,
  output logic [NUM_W:0]     rf_addr_o,
  output logic               rf_re_o,
  output logic               rf_we_o,
  output logic [2*CMD_W-1:0] rf_wdata_o,
  input  logic [2*CMD_W-1:0] rf_rdata_i
);
  localparam int unsigned DATA_W = 2 * CMD_W;

  seq_state_e       state_q, state_d;
  resp_t            resp_q, resp_d;
  logic [CMD_W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic [NUM_W:0]   addr_q, addr_d;
  logic             berr_q, berr_d;

  assign rf_addr_o  = addr_q;
  assign rf_re_o    = xfer_i && (state_q == S_RD_HI) && halted_i;
  assign rf_we_o    = xfer_i && (state_q == S_WR_LO) && halted_i;
  assign rf_wdata_o = {hi_q, word_i};
  assign resp_o     = resp_q;

  always_comb begin
    state_d = state_q;
    resp_d  = resp_q;
    hi_d    = hi_q;
    lo_d    = lo_q;
    addr_d  = addr_q;
    berr_d  = berr_q;
    if (xfer_i) begin
      unique case (state_q)
        S_IDLE: begin
          resp_d = '{status: 1'b1, data: D_NOT_READY};
          addr_d = idx_i;
          unique case (kind_i)
            CMD_RD:  state_d = S_RD_HI;
            CMD_WR:  state_d = S_WR_HI;
            default: state_d = S_ILL;
          endcase
        end
        S_RD_HI: begin
          if (halted_i) begin
            resp_d  = '{status: 1'b0, data: rf_rdata_i[DATA_W-1:CMD_W]};
            lo_d    = rf_rdata_i[CMD_W-1:0];
            state_d = S_RD_LO;
          end else begin
            resp_d  = '{status: 1'b1, data: D_BUS_ERR};
            state_d = S_IDLE;
          end
        end
        S_RD_LO: begin
          resp_d  = '{status: 1'b0, data: lo_q};
          state_d = S_IDLE;
        end
        S_WR_HI: begin
          hi_d    = word_i;
          resp_d  = '{status: 1'b1, data: D_NOT_READY};
          state_d = S_WR_LO;
        end
        S_WR_LO: begin
          berr_d  = !halted_i;
          resp_d  = '{status: 1'b1, data: D_NOT_READY};
          state_d = S_WR_DONE;
        end
        S_WR_DONE: begin
          resp_d  = berr_q ? '{status: 1'b1, data: D_BUS_ERR}
                           : '{status: 1'b0, data: D_DONE};
          state_d = S_IDLE;
        end
        S_ILL: begin
          resp_d  = '{status: 1'b1, data: D_ILLEGAL};
          state_d = S_IDLE;
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      resp_q  <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      addr_q  <= '0;
      berr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      resp_q  <= resp_d;
      hi_q    <= hi_d;
      lo_q    <= lo_d;
      addr_q  <= addr_d;
      berr_q  <= berr_d;
    end
  end

  // R10
  resp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_i |=> $stable(resp_o));

  // R2
  cmd_slot_nr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && state_q == S_IDLE) |=> (resp_o.status && resp_o.data == D_NOT_READY));

  // R11
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rf_re_o && rf_we_o));

  // R11
  strobe_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_re_o || rf_we_o) |-> (xfer_i && halted_i));

  // R3
  rd_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_re_o |=> (!resp_o.status && resp_o.data == $past(rf_rdata_i[DATA_W-1:CMD_W])));
endmodule

// File: rtl/dbgreg_cmd_engine.sv
module dbgreg_cmd_engine
  import dbgreg_cmd_pkg::*;
#(
  parameter int unsigned NUM_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             xfer_i,
  input  logic [15:0]      word_i,
  input  logic             halted_i,
  output logic             resp_status_o,
  output logic [15:0]      resp_data_o,
  output logic [NUM_W:0]   rf_addr_o,
  output logic             rf_re_o,
  output logic             rf_we_o,
  output logic [31:0]      rf_wdata_o,
  input  logic [31:0]      rf_rdata_i
);
  cmd_kind_e      kind;
  logic [NUM_W:0] idx;
  resp_t          resp;

  dbgreg_cmd_decode #(.NUM_W(NUM_W)) u_decode (
    .word_i (word_i),
    .kind_o (kind),
    .idx_o  (idx)
  );

  dbgreg_cmd_seq #(.NUM_W(NUM_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .xfer_i     (xfer_i),
    .word_i     (word_i),
    .halted_i   (halted_i),
    .kind_i     (kind),
    .idx_i      (idx),
    .resp_o     (resp),
    .rf_addr_o  (rf_addr_o),
    .rf_re_o    (rf_re_o),
    .rf_we_o    (rf_we_o),
    .rf_wdata_o (rf_wdata_o),
    .rf_rdata_i (rf_rdata_i)
  );

  assign resp_status_o = resp.status;
  assign resp_data_o   = resp.data;
endmodule

// File: tb/dbgreg_cmd_engine_bench.sv
module dbgreg_cmd_engine_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        xfer_i = 1'b0;
  logic [15:0] word_i = '0;
  logic        halted_i = 1'b1;
  logic        resp_status_o;
  logic [15:0] resp_data_o;
  logic [3:0]  rf_addr_o;
  logic        rf_re_o, rf_we_o;
  logic [31:0] rf_wdata_o, rf_rdata_i;

  logic [31:0] rf_mem  [16];
  logic [31:0] ref_mem [16];
  int re_cnt = 0, we_cnt = 0, bad_strobe = 0;
  int checks = 0, errors = 0;
  logic have_last = 1'b0;
  logic [16:0] last_resp;

  always #4 clk_i = ~clk_i;

  dbgreg_cmd_engine u_dbgreg_cmd_engine (
    .clk_i, .rst_ni, .xfer_i, .word_i, .halted_i,
    .resp_status_o, .resp_data_o, .rf_addr_o,
    .rf_re_o, .rf_we_o, .rf_wdata_o, .rf_rdata_i
  );

  assign rf_rdata_i = rf_mem[rf_addr_o];

  always @(posedge clk_i) begin
    if (rf_we_o) rf_mem[rf_addr_o] <= rf_wdata_o;
    if (rf_re_o) re_cnt <= re_cnt + 1;
    if (rf_we_o) we_cnt <= we_cnt + 1;
    if ((rf_re_o && rf_we_o) || ((rf_re_o || rf_we_o) && (!xfer_i || !halted_i)))
      bad_strobe <= bad_strobe + 1;
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_resp(input string req, input logic s, input logic [15:0] d,
                          input logic es, input logic [15:0] ed);
    chk(s == es && d == ed, req, {15'd0, s, d}, {15'd0, es, ed});
  endtask

  // one transfer slot; verifies the response held through the preceding gap (R10)
  task automatic slot(input logic [15:0] w, output logic s, output logic [15:0] d);
    @(negedge clk_i);
    if (have_last)
      chk({resp_status_o, resp_data_o} == last_resp, "R10", {15'd0, resp_status_o, resp_data_o}, {15'd0, last_resp});
    xfer_i = 1'b1;
    word_i = w;
    @(negedge clk_i);
    xfer_i = 1'b0;
    word_i = 16'h5A5A;
    s = resp_status_o;
    d = resp_data_o;
    last_resp = {s, d};
    have_last = 1'b1;
  endtask

  function automatic logic [15:0] cmd(input logic rd, input int idx);
    return 16'h2080 | (rd ? 16'h0100 : 16'h0000) | 16'(idx);
  endfunction

  task automatic do_write(input int idx, input logic [31:0] v, input logic h);
    logic s; logic [15:0] d; int we0;
    halted_i = h;
    we0 = we_cnt;
    slot(cmd(1'b0, idx), s, d);  chk_resp("R2 wr cmd", s, d, 1'b1, 16'h0000);
    slot(v[31:16], s, d);        chk_resp("R2 wr hi", s, d, 1'b1, 16'h0000);
    slot(v[15:0], s, d);         chk_resp("R2 wr lo", s, d, 1'b1, 16'h0000);
    slot(16'h0000, s, d);
    if (h) begin
      chk_resp("R4 wr done", s, d, 1'b0, 16'hFFFF);
      ref_mem[idx] = v;
      chk(we_cnt == we0 + 1, "R4 one strobe", we_cnt, we0 + 1);
    end else begin
      chk_resp("R6 wr berr", s, d, 1'b1, 16'h0001);
      chk(we_cnt == we0, "R6 no strobe", we_cnt, we0);
    end
    chk(rf_mem[idx] == ref_mem[idx], h ? "R4 stored" : "R6 kept", rf_mem[idx], ref_mem[idx]);
  endtask

  task automatic do_read(input int idx, input logic h);
    logic s; logic [15:0] d; int re0;
    halted_i = h;
    re0 = re_cnt;
    slot(cmd(1'b1, idx), s, d);  chk_resp("R2 rd cmd", s, d, 1'b1, 16'h0000);
    slot(16'h0000, s, d);
    if (h) begin
      chk_resp("R3 upper", s, d, 1'b0, ref_mem[idx][31:16]);
      slot(16'h0000, s, d);
      chk_resp("R3 lower", s, d, 1'b0, ref_mem[idx][15:0]);
      chk(rf_addr_o == 4'(idx), "R1 addr", rf_addr_o, idx);
    end else begin
      chk_resp("R5 rd berr", s, d, 1'b1, 16'h0001);
      chk(re_cnt == re0, "R5 no strobe", re_cnt, re0);
    end
  endtask

  task automatic do_illegal(input logic [15:0] w);
    logic s; logic [15:0] d; int re0, we0;
    halted_i = 1'b1;
    re0 = re_cnt; we0 = we_cnt;
    slot(w, s, d);         chk_resp("R7 cmd nr", s, d, 1'b1, 16'h0000);
    slot(16'h0000, s, d);  chk_resp("R7 illegal", s, d, 1'b1, 16'hFFFF);
    chk(re_cnt == re0 && we_cnt == we0, "R7 no access", re_cnt + we_cnt, re0 + we0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      rf_mem[i]  = 32'h0101_0101 * 32'(i) ^ 32'hC3A5_5A3C;
      ref_mem[i] = rf_mem[i];
    end
    repeat (3) @(negedge clk_i);
    chk_resp("R9 reset resp", resp_status_o, resp_data_o, 1'b0, 16'h0000);
    chk(!rf_re_o && !rf_we_o, "R9 strobes", {rf_re_o, rf_we_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_resp("R9 after reset", resp_status_o, resp_data_o, 1'b0, 16'h0000);

    // R1 R4: write every register, back to back (R8)
    for (int i = 0; i < 16; i++) do_write(i, 32'h9E37_79B9 * 32'(i + 1), 1'b1);
    // R1 R3: read every register; each read follows the previous with no gap (R8)
    for (int i = 0; i < 16; i++) do_read(i, 1'b1);
    // R5 R6: core running
    for (int i = 0; i < 16; i++) begin
      do_write(i, ~ref_mem[i], 1'b0);
      do_read(i, 1'b0);
      do_read(i, 1'b1);  // R8 next slot is a fresh command
    end
    // R1 R7: sweep each opcode field over all values
    for (int f = 0; f < 16; f++) begin
      if (f != 2) do_illegal({4'(f), 4'h1, 4'h8, 4'h3});
      if (f != 8) do_illegal({4'h2, 4'h0, 4'(f), 4'h5});
      if (f > 1)  do_illegal({4'h2, 4'(f), 4'h8, 4'h9});
    end
    do_read(13, 1'b1);  // R8 after illegal
    @(negedge clk_i);
    chk(bad_strobe == 0, "R11 strobes", bad_strobe, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule